// File: doc/BRIEF.md
# Header-Driven Route Mode Selector

This block watches a packet stream of 24-bit phits and decides, once per packet, how that packet leaves the router. Three flag bits in the head phit choose the mode. The mode is source routing, adaptive routing or deterministic routing, and deterministic routing can be plain or hashed. A fourth head bit tags the virtual channel as request or response. The block returns an output port, the virtual channel, a mode code and, for source-routed packets, the rest of the routing vector for the next hop.

Adaptive decisions compare per-port free-credit counts against a candidate mask, and both come from the caller. Deterministic decisions read a small table indexed by a destination field of the head phit. The hashed variant also needs a second phit, because its hash bits only arrive there. Once a decision is made it stays registered and frozen until the packet's tail phit has been accepted, so every phit of one packet follows the same route. Downstream logic paces the remaining phits with `dec_ready`.

Field layout of the head phit: bits 23:22 carry link sideband; bit 21 is the source flag; bit 20 is the adaptive flag; bit 19 is the hash flag; bit 18 is the channel bit; bits 15:12 are the table index; bits 11:0 are the routing vector. The vector holds four 3-bit port entries, and the entry for the current hop is in bits 2:0.

Top module: `route_mode_sel`

## Requirements
- R1: Bits 23:22 of every phit have no effect on any decision output.
- R2: `dec_vc` equals bit 18 of the head phit (0 request, 1 response) for the whole packet.
- R3: With bit 21 set, the mode code is 3, `dec_port` is head bits 2:0, and `dec_vec` is head bits 11:0 shifted right by 3 with zero fill.
- R4: The source flag takes precedence: with bit 21 set, the values of bits 20 and 19 do not change the decision.
- R5: With bit 21 clear and bit 20 set, the mode code is 2 and `dec_port` is the port in `cand_mask` with the highest credit count (port i at `cred[4i+3:4i]`). Ties go to the lowest index. An empty mask gives port 0. Mask and credits are sampled when the head phit is accepted.
- R6: With bits 21, 20 and 19 all clear, the mode code is 0 and `dec_port` is the table entry addressed by head bits 15:12.
- R7: With bits 21 and 20 clear and bit 19 set, the mode code is 1. `dec_valid` stays low until the second phit is accepted. `dec_port` is then the table entry for head bits 15:12 XOR bits 2:0 of the second phit.
- R8: A cycle with `tbl_we` high writes `tbl_port` into entry `tbl_addr`, and decisions made from the following cycle on use the new entry.
- R9: `dec_valid` rises the cycle after the deciding phit is accepted. While it is high, port, channel, mode and vector stay stable until the tail phit (`in_last`) is accepted. `dec_valid` is low in the cycle after that.
- R10: `in_ready` is high while no decision is held. While a decision is held, `in_ready` equals `dec_ready`.
- R11: After reset, `dec_valid` is low, `in_ready` is high, and table entry i holds i modulo 8.
- R12: In modes 0, 1 and 2, `dec_vec` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Phit present |
| in_ready | output | 1 | Phit accepted this cycle when valid |
| in_data | input | 24 | Phit contents |
| in_last | input | 1 | Phit is the packet tail |
| cand_mask | input | 8 | Ports allowed for adaptive choice |
| cred | input | 32 | Free credits, 4 bits per port |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry to write |
| tbl_port | input | 3 | Port value to write |
| dec_valid | output | 1 | Decision held |
| dec_ready | input | 1 | Downstream takes phits of this packet |
| dec_port | output | 3 | Chosen output port |
| dec_vc | output | 1 | Virtual channel tag |
| dec_mode | output | 2 | 0 plain, 1 hashed, 2 adaptive, 3 source |
| dec_vec | output | 12 | Remaining routing vector |

## Verification
On every cycle the assertions check three things: a held decision stays frozen until its tail is accepted and is released just after; non-source modes carry a zero vector; and a fresh source or adaptive decision matches the phit and mask it came from. Other behaviours can only be shown by the bench's packet scenarios against a table model: ignored sideband bits, the delay imposed by the hashed mode, table rewrites, tie breaking between equal credit counts, and precedence of the source flag.

// File: rtl/route_mode_sel.sv
module route_mode_sel #(
  parameter int NPORT = 8,
  parameter int CW    = 4,
  parameter int TAW   = 4,
  parameter int HOPS  = 4,
  localparam int PW   = $clog2(NPORT),
  localparam int VW   = HOPS * PW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [23:0]         in_data,
  input  logic                in_last,
  input  logic [NPORT-1:0]    cand_mask,
  input  logic [NPORT*CW-1:0] cred,
  input  logic                tbl_we,
  input  logic [TAW-1:0]      tbl_addr,
  input  logic [PW-1:0]       tbl_port,
  output logic                dec_valid,
  input  logic                dec_ready,
  output logic [PW-1:0]       dec_port,
  output logic                dec_vc,
  output logic [1:0]          dec_mode,
  output logic [VW-1:0]       dec_vec
);
  localparam logic [1:0] M_DET = 2'd0, M_HSH = 2'd1, M_ADP = 2'd2, M_SRC = 2'd3;
  localparam int NTBL = 2 ** TAW;

  typedef enum logic [1:0] {S_IDLE, S_HASH, S_ROUTE} st_t;
  st_t st;

  logic [PW-1:0]  tbl [NTBL];
  logic [TAW-1:0] dst_r;

  wire          f_src = in_data[21];
  wire          f_adp = in_data[20];
  wire          f_hsh = in_data[19];
  wire          f_vc  = in_data[18];
  wire [TAW-1:0] f_dst = in_data[12 +: TAW];
  wire [VW-1:0]  f_vec = in_data[VW-1:0];

  assign dec_valid = (st == S_ROUTE);
  assign in_ready  = dec_valid ? dec_ready : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTBL; i++) tbl[i] <= PW'(i);
    end else if (tbl_we) begin
      tbl[tbl_addr] <= tbl_port;
    end
  end

  logic [PW-1:0] adp_port;
  logic [CW-1:0] best;
  logic          found;
  always_comb begin
    adp_port = '0;
    best     = '0;
    found    = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (cand_mask[i] && (!found || cred[i*CW +: CW] > best)) begin
        found    = 1'b1;
        best     = cred[i*CW +: CW];
        adp_port = PW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      dst_r    <= '0;
      dec_port <= '0;
      dec_vc   <= 1'b0;
      dec_mode <= M_DET;
      dec_vec  <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          dec_vc  <= f_vc;
          dst_r   <= f_dst;
          dec_vec <= '0;
          if (f_src) begin
            dec_port <= f_vec[PW-1:0];
            dec_vec  <= f_vec >> PW;
            dec_mode <= M_SRC;
            st       <= S_ROUTE;
          end else if (f_adp) begin
            dec_port <= adp_port;
            dec_mode <= M_ADP;
            st       <= S_ROUTE;
          end else if (f_hsh) begin
            dec_mode <= M_HSH;
            st       <= S_HASH;
          end else begin
            dec_port <= tbl[f_dst];
            dec_mode <= M_DET;
            st       <= S_ROUTE;
          end
        end
        S_HASH: if (in_valid) begin
          dec_port <= tbl[dst_r] ^ in_data[PW-1:0];
          st       <= S_ROUTE;
        end
        S_ROUTE: if (in_valid && dec_ready && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_HOLD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !(in_valid && dec_ready && in_last) |=>
      dec_valid && $stable(dec_port) && $stable(dec_vc) && $stable(dec_mode) && $stable(dec_vec)); // R9
  AST_TAIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && in_valid && dec_ready && in_last |=> !dec_valid); // R9
  AST_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_mode != M_SRC |-> dec_vec == '0); // R12
  AST_SRC_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) && dec_mode == M_SRC |-> dec_port == $past(in_data[PW-1:0])); // R3
  AST_ADP_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) && dec_mode == M_ADP && $past(cand_mask) != '0 |->
      (($past(cand_mask) >> dec_port) & NPORT'(1)) != '0); // R5
endmodule

// File: tb/route_mode_sel_bench.sv
module route_mode_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, dec_ready = 1'b1, tbl_we = 1'b0;
  logic [23:0] in_data = '0;
  logic [7:0]  cand_mask = '0;
  logic [31:0] cred = '0;
  logic [3:0]  tbl_addr = '0;
  logic [2:0]  tbl_port = '0;
  logic        in_ready, dec_valid, dec_vc;
  logic [2:0]  dec_port;
  logic [1:0]  dec_mode;
  logic [11:0] dec_vec;

  int n_chk = 0, n_bad = 0;
  logic [2:0] mdl [16];

  always #5ns clk = ~clk;

  route_mode_sel u_route_mode_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .cand_mask(cand_mask), .cred(cred),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_port(tbl_port),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_port(dec_port),
    .dec_vc(dec_vc), .dec_mode(dec_mode), .dec_vec(dec_vec));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] pick_adp(input logic [7:0] m, input logic [31:0] c);
    logic [2:0] p = 3'd0;
    logic [3:0] b = 4'd0;
    logic f = 1'b0;
    for (int i = 0; i < 8; i++)
      if (m[i] && (!f || c[i*4 +: 4] > b)) begin f = 1'b1; b = c[i*4 +: 4]; p = 3'(i); end
    return p;
  endfunction

  task automatic tbl_write(input logic [3:0] a, input logic [2:0] p);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_port = p;
    @(negedge clk);
    tbl_we = 1'b0;
    mdl[a] = p;
  endtask

  task automatic run_pkt(input string tag, input logic [23:0] hd, input logic [23:0] sd,
                         input int len, input logic [7:0] m, input logic [31:0] c);
    logic [2:0]  ep;
    logic [1:0]  em;
    logic [11:0] ev;
    int sent;
    ev = '0;
    if (hd[21]) begin em = 2'd3; ep = hd[2:0]; ev = hd[11:0] >> 3; end
    else if (hd[20]) begin em = 2'd2; ep = pick_adp(m, c); end
    else if (hd[19]) begin em = 2'd1; ep = mdl[hd[15:12]] ^ sd[2:0]; end
    else begin em = 2'd0; ep = mdl[hd[15:12]]; end
    @(negedge clk);
    cand_mask = m; cred = c; in_valid = 1'b1; in_data = hd; in_last = 1'b0; dec_ready = 1'b1;
    check({tag, " R10 idle in_ready"}, 32'(in_ready), 32'd1);
    @(negedge clk);
    sent = 1;
    if (em == 2'd1) begin
      check({tag, " R7 waits for second phit"}, 32'(dec_valid), 32'd0);
      in_data = sd;
      @(negedge clk);
      sent = 2;
    end
    check({tag, " R9 valid after decision"}, 32'(dec_valid), 32'd1);
    check({tag, " R2 vc"}, 32'(dec_vc), 32'(hd[18]));
    check({tag, " R3/R5/R6/R7 port"}, 32'(dec_port), 32'(ep));
    check({tag, " mode R3 R5 R6 R7"}, 32'(dec_mode), 32'(em));
    check({tag, " vec R3 R12"}, 32'(dec_vec), 32'(ev));
    cand_mask = 8'($urandom); cred = $urandom;
    while (sent < len) begin
      in_data = 24'($urandom);
      in_last = (sent == len - 1);
      dec_ready = ($urandom % 4) != 0;
      #1ns;
      check({tag, " R10 held in_ready"}, 32'(in_ready), 32'(dec_ready));
      @(negedge clk);
      if (dec_ready) sent++;
      if (sent < len)
        check({tag, " R9 hold port"}, {28'(dec_port), 1'b0, dec_valid, dec_mode}, {28'(ep), 1'b0, 1'b1, em});
    end
    check({tag, " R9 release after tail"}, 32'(dec_valid), 32'd0);
    in_valid = 1'b0; in_last = 1'b0; dec_ready = 1'b1;
  endtask

  initial begin
    repeat (1500) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    for (int i = 0; i < 16; i++) mdl[i] = 3'(i);
    repeat (2) @(negedge clk);
    check("R11 reset dec_valid", 32'(dec_valid), 32'd0);
    check("R11 reset in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    run_pkt("R11 reset table", 24'h00_9000, 24'h0, 4, 8'h0, 32'h0);
    run_pkt("R3 source", 24'h20_0ACE, 24'h0, 5, 8'h0, 32'h0);
    run_pkt("R4 all flags", 24'h3C_0F53, 24'h0, 4, 8'hFF, 32'hFFFF_FFFF);
    run_pkt("R5 tie", 24'h10_0000, 24'h0, 4, 8'b0001_0100, 32'h7777_7777);
    run_pkt("R5 max", 24'h14_0000, 24'h0, 4, 8'b1000_0011, 32'h9000_0023);
    run_pkt("R5 empty", 24'h10_0000, 24'h0, 4, 8'h0, 32'hFFFF_FFFF);
    run_pkt("R7 hash", 24'h08_5000, 24'hC0_0003, 6, 8'h0, 32'h0);
    tbl_write(4'd6, 3'd1);
    run_pkt("R8 table write", 24'h00_6000, 24'h0, 4, 8'h0, 32'h0);
    run_pkt("R1 sideband off", 24'h04_3000, 24'h0, 4, 8'h0, 32'h0);
    run_pkt("R1 sideband on", 24'hC4_3000, 24'hC0_0000, 4, 8'h0, 32'h0);
    for (int k = 0; k < 40; k++) begin
      if (k % 10 == 3) tbl_write(4'($urandom), 3'($urandom));
      run_pkt("rand R1", 24'($urandom), 24'($urandom), 4 + int'($urandom % 4),
              8'($urandom), $urandom);
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule